// File: doc/BRIEF.md
# Single-Bus Processor Datapath

This block is the register and arithmetic half of a 32-bit processor whose units all meet on one shared internal bus. It holds the general register file (32 entries), the program counter, the instruction register, a memory address register, a memory data register, an ALU input latch and an ALU result latch. A separate controller sequences it by raising gate inputs, which pick the one source that drives the bus, and strobe inputs, which load destinations from the bus at the next rising clock edge. Each register transfer step of an instruction therefore maps onto one clock cycle and one set of gate and strobe levels.

The first ALU operand is always the input latch and the second is always the bus, and the result can only land in the result latch. Two sign-extended constants can be gated out of the instruction register. A base-address gate reads register 0 as zero. A one-bit condition flag and a 5-bit loop counter give the controller its branch and shift decisions. External memory is reached through the address and data registers and a small handshake state machine. It has three states: `MEM_IDLE`, `MEM_READ` and `MEM_WRITE`. It moves from `MEM_IDLE` to `MEM_READ` on a read request, and from `MEM_IDLE` to `MEM_WRITE` on a write request when no read is requested. From either busy state it returns to `MEM_IDLE` in the cycle memory signals done. A read also copies the returned word into the data register in that cycle.

Top module: `onebus_datapath`

## Requirements
- R1: After reset the bus reads zero, the condition flag is 0, the counter-zero flag is 1, neither memory request output is high, the memory address output is zero and the program counter gated out reads zero.
- R2: At most one gate input is high per cycle, and the bus reads zero in a cycle where no gate input is high.
- R3: The register index is taken from IR[26:22] under `sel_ra`, from IR[21:17] under `sel_rb` and from IR[16:12] under `sel_rc`. `r_out` drives the indexed register onto the bus and `r_in` loads it from the bus.
- R4: `ba_out` drives the indexed register like `r_out`, except that it drives zero when the index is 0, whatever register 0 holds.
- R5: `c2_out` drives IR[16:0] sign-extended from bit 16, and `c1_out` drives IR[21:0] sign-extended from bit 21.
- R6: With `c_in` high, C loads f(A, bus), where `alu_op` selects f. The codes are: 0 A+B, 1 A-B, 2 A&B, 3 A|B, 4 B logical right by one, 5 B arithmetic right by one, 6 B left by one, 7 B rotated left by one, 8 ~B, 9 -B, 10 B, 11 B+4, and 12 to 15 give zero.
- R7: With `con_in` high, the condition flag loads a test of the bus value selected by IR[2:0]. The codes are: 0 false, 1 true, 2 value is zero, 3 value is nonzero, 4 bit 31 clear, 5 bit 31 set, and 6 and 7 false.
- R8: The counter loads bus[4:0] on `n_ld` and otherwise decrements by one on `n_dec`. A decrement at zero leaves it at zero. `n_zero` is high exactly when the count is zero.
- R9: A `mem_read` pulse raises `mem_rd` from the next cycle until the cycle `mem_done` is seen. MD takes `mem_rdata` at that edge, and `mem_rd` is low after it.
- R10: A `mem_write` pulse raises `mem_wr` from the next cycle until `mem_done` is seen. During that time `mem_wdata` shows MD and `mem_addr` shows MA.
- R11: PC, IR and MA load only from the bus. MA changes only on `ma_in`. One cycle of PC gated out with `alu_op` 11 into C, followed by a cycle of C gated out into PC, advances PC by 4.
- R12: `clr_pc` zeroes PC at the next edge, ahead of `pc_in`. `clr_gpr` zeroes all 32 general registers at the next edge.
- R13: `ir_op` shows IR[31:27].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | rising-edge clock |
| rst | input | 1 | synchronous reset of all registers except the general registers |
| clr_pc | input | 1 | synchronous clear of PC |
| clr_gpr | input | 1 | synchronous clear of all general registers |
| pc_out | input | 1 | gate PC onto bus |
| md_out | input | 1 | gate MD onto bus |
| c_out | input | 1 | gate C onto bus |
| r_out | input | 1 | gate indexed register onto bus |
| ba_out | input | 1 | gate indexed register, zero for index 0 |
| c1_out | input | 1 | gate long sign-extended constant |
| c2_out | input | 1 | gate short sign-extended constant |
| pc_in | input | 1 | load PC from bus |
| ir_in | input | 1 | load IR from bus |
| ma_in | input | 1 | load MA from bus |
| md_in | input | 1 | load MD from bus |
| a_in | input | 1 | load A from bus |
| c_in | input | 1 | load C from ALU |
| r_in | input | 1 | load indexed register from bus |
| con_in | input | 1 | load condition flag |
| n_ld | input | 1 | load counter from bus[4:0] |
| n_dec | input | 1 | decrement counter |
| sel_ra | input | 1 | index from IR[26:22] |
| sel_rb | input | 1 | index from IR[21:17] |
| sel_rc | input | 1 | index from IR[16:12] |
| alu_op | input | 4 | ALU function code |
| mem_read | input | 1 | start a memory read |
| mem_write | input | 1 | start a memory write |
| mem_done | input | 1 | memory completion |
| mem_rdata | input | 32 | read data from memory |
| mem_addr | output | 32 | address (MA) |
| mem_wdata | output | 32 | write data (MD) |
| mem_rd | output | 1 | read in progress |
| mem_wr | output | 1 | write in progress |
| bus_o | output | 32 | internal bus value |
| con_o | output | 1 | condition flag |
| n_zero | output | 1 | counter is zero |
| ir_op | output | 5 | IR[31:27] |

## Verification
Several properties are checked in every cycle: the gates stay one-hot, the bus stays idle when no gate is high, memory requests hold until done and never overlap, MD captures read data, the counter steps down and floors at zero, PC clears, and MA holds between loads. The bench's scenarios show the rest. These are the values each ALU code produces over a grid of operand pairs, every condition code against edge-case values, register field decoding and the register 0 base-address rule, both constant extensions, the increment-by-4 fetch pattern, and the two clear inputs reaching all 32 registers.

// File: rtl/obd_pkg.sv
package obd_pkg;
    localparam int DW       = 32;
    localparam int RA_LO    = 22;
    localparam int RB_LO    = 17;
    localparam int RC_LO    = 12;
    localparam int OP_LO    = 27;
    localparam int OP_W     = 5;
    localparam int C1_SIGN  = 21;
    localparam int C2_SIGN  = 16;
    localparam int CND_W    = 3;

    typedef enum logic [3:0] {
        ALU_ADD  = 4'd0,
        ALU_SUB  = 4'd1,
        ALU_AND  = 4'd2,
        ALU_OR   = 4'd3,
        ALU_SHR  = 4'd4,
        ALU_SHRA = 4'd5,
        ALU_SHL  = 4'd6,
        ALU_ROL  = 4'd7,
        ALU_NOT  = 4'd8,
        ALU_NEG  = 4'd9,
        ALU_PASS = 4'd10,
        ALU_INC4 = 4'd11
    } alu_op_e;

    typedef enum logic [1:0] {
        MEM_IDLE  = 2'd0,
        MEM_READ  = 2'd1,
        MEM_WRITE = 2'd2
    } mem_state_e;
endpackage

// File: rtl/obd_regfile.sv
module obd_regfile #(
    parameter int NREG   = 32,
    parameter int WIDTH  = 32,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             clr_all,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (clr_all) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we) begin
            regs[idx] <= wdata;
        end
    end

    assign rdata = regs[idx];
endmodule

// File: rtl/obd_alu.sv
module obd_alu
    import obd_pkg::*;
(
    input  logic [3:0]    op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y
);
    always_comb begin
        unique case (op)
            ALU_ADD:  y = a + b;
            ALU_SUB:  y = a - b;
            ALU_AND:  y = a & b;
            ALU_OR:   y = a | b;
            ALU_SHR:  y = {1'b0, b[DW-1:1]};
            ALU_SHRA: y = {b[DW-1], b[DW-1:1]};
            ALU_SHL:  y = {b[DW-2:0], 1'b0};
            ALU_ROL:  y = {b[DW-2:0], b[DW-1]};
            ALU_NOT:  y = ~b;
            ALU_NEG:  y = '0 - b;
            ALU_PASS: y = b;
            ALU_INC4: y = b + DW'(4);
            default:  y = '0;
        endcase
    end
endmodule

// File: rtl/obd_cond.sv
module obd_cond
    import obd_pkg::*;
(
    input  logic [CND_W-1:0] code,
    input  logic [DW-1:0]    val,
    output logic             take
);
    always_comb begin
        unique case (code)
            3'd1:    take = 1'b1;
            3'd2:    take = (val == '0);
            3'd3:    take = (val != '0);
            3'd4:    take = ~val[DW-1];
            3'd5:    take = val[DW-1];
            default: take = 1'b0;
        endcase
    end
endmodule

// File: rtl/obd_shcnt.sv
module obd_shcnt #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic         dec,
    input  logic [W-1:0] din,
    output logic [W-1:0] cnt,
    output logic         zero
);
    always_ff @(posedge clk) begin
        if (rst)                   cnt <= '0;
        else if (ld)               cnt <= din;
        else if (dec && cnt != '0) cnt <= cnt - W'(1);
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/obd_memport.sv
module obd_memport
    import obd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rd_req,
    input  logic wr_req,
    input  logic done,
    output logic rd_o,
    output logic wr_o,
    output logic capture
);
    mem_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= MEM_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        rd_o    = 1'b0;
        wr_o    = 1'b0;
        capture = 1'b0;
        unique case (state_q)
            MEM_IDLE: begin
                if (rd_req)      state_d = MEM_READ;
                else if (wr_req) state_d = MEM_WRITE;
            end
            MEM_READ: begin
                rd_o = 1'b1;
                if (done) begin
                    capture = 1'b1;
                    state_d = MEM_IDLE;
                end
            end
            MEM_WRITE: begin
                wr_o = 1'b1;
                if (done) state_d = MEM_IDLE;
            end
            default: state_d = MEM_IDLE;
        endcase
    end
endmodule

// File: rtl/onebus_datapath.sv
module onebus_datapath
    import obd_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int CNT_W = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_pc,
    input  logic          clr_gpr,
    input  logic          pc_out,
    input  logic          md_out,
    input  logic          c_out,
    input  logic          r_out,
    input  logic          ba_out,
    input  logic          c1_out,
    input  logic          c2_out,
    input  logic          pc_in,
    input  logic          ir_in,
    input  logic          ma_in,
    input  logic          md_in,
    input  logic          a_in,
    input  logic          c_in,
    input  logic          r_in,
    input  logic          con_in,
    input  logic          n_ld,
    input  logic          n_dec,
    input  logic          sel_ra,
    input  logic          sel_rb,
    input  logic          sel_rc,
    input  logic [3:0]    alu_op,
    input  logic          mem_read,
    input  logic          mem_write,
    input  logic          mem_done,
    input  logic [31:0]   mem_rdata,
    output logic [31:0]   mem_addr,
    output logic [31:0]   mem_wdata,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [31:0]   bus_o,
    output logic          con_o,
    output logic          n_zero,
    output logic [4:0]    ir_op
);
    localparam int IDX_W = $clog2(NREG);

    logic [DW-1:0]    pc_q, ir_q, ma_q, md_q, a_q, c_q;
    logic [DW-1:0]    bus, alu_y, gpr_rd, c1_val, c2_val;
    logic [IDX_W-1:0] ridx;
    logic             con_q, cond_take, md_capture;
    logic [CNT_W-1:0] n_cnt;

    always_comb begin
        if (sel_ra)      ridx = ir_q[RA_LO +: IDX_W];
        else if (sel_rb) ridx = ir_q[RB_LO +: IDX_W];
        else if (sel_rc) ridx = ir_q[RC_LO +: IDX_W];
        else             ridx = '0;
    end

    assign c1_val = {{(DW-C1_SIGN-1){ir_q[C1_SIGN]}}, ir_q[C1_SIGN:0]};
    assign c2_val = {{(DW-C2_SIGN-1){ir_q[C2_SIGN]}}, ir_q[C2_SIGN:0]};

    assign bus = ({DW{pc_out}} & pc_q)
               | ({DW{md_out}} & md_q)
               | ({DW{c_out}}  & c_q)
               | ({DW{r_out}}  & gpr_rd)
               | ({DW{ba_out && (ridx != '0)}} & gpr_rd)
               | ({DW{c1_out}} & c1_val)
               | ({DW{c2_out}} & c2_val);

    obd_regfile #(.NREG(NREG), .WIDTH(DW)) u_gpr (
        .clk     (clk),
        .clr_all (clr_gpr),
        .we      (r_in),
        .idx     (ridx),
        .wdata   (bus),
        .rdata   (gpr_rd)
    );

    obd_alu u_alu (.op(alu_op), .a(a_q), .b(bus), .y(alu_y));

    obd_cond u_cond (.code(ir_q[CND_W-1:0]), .val(bus), .take(cond_take));

    obd_shcnt #(.W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .ld   (n_ld),
        .dec  (n_dec),
        .din  (bus[CNT_W-1:0]),
        .cnt  (n_cnt),
        .zero (n_zero)
    );

    obd_memport u_mem (
        .clk     (clk),
        .rst     (rst),
        .rd_req  (mem_read),
        .wr_req  (mem_write),
        .done    (mem_done),
        .rd_o    (mem_rd),
        .wr_o    (mem_wr),
        .capture (md_capture)
    );

    always_ff @(posedge clk) begin
        if (rst || clr_pc) pc_q <= '0;
        else if (pc_in)    pc_q <= bus;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ir_q  <= '0;
            ma_q  <= '0;
            md_q  <= '0;
            a_q   <= '0;
            c_q   <= '0;
            con_q <= 1'b0;
        end else begin
            if (ir_in)  ir_q <= bus;
            if (ma_in)  ma_q <= bus;
            if (a_in)   a_q  <= bus;
            if (c_in)   c_q  <= alu_y;
            if (con_in) con_q <= cond_take;
            if (md_capture) md_q <= mem_rdata;
            else if (md_in) md_q <= bus;
        end
    end

    assign mem_addr  = ma_q;
    assign mem_wdata = md_q;
    assign bus_o     = bus;
    assign con_o     = con_q;
    assign ir_op     = ir_q[OP_LO +: OP_W];
endmodule

// File: rtl/obd_checks.sv
module obd_checks (
    input logic        clk,
    input logic        rst,
    input logic        clr_pc,
    input logic        pc_out,
    input logic        md_out,
    input logic        c_out,
    input logic        r_out,
    input logic        ba_out,
    input logic        c1_out,
    input logic        c2_out,
    input logic        ma_in,
    input logic        n_ld,
    input logic        n_dec,
    input logic        mem_done,
    input logic [31:0] mem_rdata,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_rd,
    input logic        mem_wr,
    input logic [31:0] bus_o,
    input logic        n_zero,
    input logic [4:0]  n_q,
    input logic [31:0] pc_q
);
    a_r2_one_driver: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pc_out, md_out, c_out, r_out, ba_out, c1_out, c2_out}));

    a_r2_idle_bus: assert property (@(posedge clk) disable iff (rst)
        !(pc_out || md_out || c_out || r_out || ba_out || c1_out || c2_out) |-> (bus_o == 32'd0));

    a_r9_rd_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && !mem_done) |=> mem_rd);

    a_r9_md_capture: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && mem_done) |=> (mem_wdata == $past(mem_rdata)));

    a_r10_wr_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && !mem_done) |=> mem_wr);

    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    a_r8_step_down: assert property (@(posedge clk) disable iff (rst)
        (n_dec && !n_ld && !n_zero) |=> (n_q == $past(n_q) - 5'd1));

    a_r8_floor: assert property (@(posedge clk) disable iff (rst)
        (n_dec && !n_ld && n_zero) |=> n_zero);

    a_r12_pc_clear: assert property (@(posedge clk) disable iff (rst)
        clr_pc |=> (pc_q == 32'd0));

    a_r11_ma_hold: assert property (@(posedge clk) disable iff (rst)
        !ma_in |=> $stable(mem_addr));
endmodule

bind onebus_datapath obd_checks u_obd_checks (
    .clk       (clk),
    .rst       (rst),
    .clr_pc    (clr_pc),
    .pc_out    (pc_out),
    .md_out    (md_out),
    .c_out     (c_out),
    .r_out     (r_out),
    .ba_out    (ba_out),
    .c1_out    (c1_out),
    .c2_out    (c2_out),
    .ma_in     (ma_in),
    .n_ld      (n_ld),
    .n_dec     (n_dec),
    .mem_done  (mem_done),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .bus_o     (bus_o),
    .n_zero    (n_zero),
    .n_q       (n_cnt),
    .pc_q      (pc_q)
);

// File: tb/onebus_datapath_tb_top.sv
module onebus_datapath_tb_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst, clr_pc, clr_gpr;
    logic pc_out, md_out, c_out, r_out, ba_out, c1_out, c2_out;
    logic pc_in, ir_in, ma_in, md_in, a_in, c_in, r_in, con_in, n_ld, n_dec;
    logic sel_ra, sel_rb, sel_rc;
    logic [3:0]  alu_op;
    logic mem_read, mem_write, mem_done;
    logic [31:0] mem_rdata, mem_addr, mem_wdata, bus_o;
    logic mem_rd, mem_wr, con_o, n_zero;
    logic [4:0] ir_op;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    onebus_datapath dut_i (
        .clk(clk), .rst(rst), .clr_pc(clr_pc), .clr_gpr(clr_gpr),
        .pc_out(pc_out), .md_out(md_out), .c_out(c_out), .r_out(r_out),
        .ba_out(ba_out), .c1_out(c1_out), .c2_out(c2_out),
        .pc_in(pc_in), .ir_in(ir_in), .ma_in(ma_in), .md_in(md_in),
        .a_in(a_in), .c_in(c_in), .r_in(r_in), .con_in(con_in),
        .n_ld(n_ld), .n_dec(n_dec),
        .sel_ra(sel_ra), .sel_rb(sel_rb), .sel_rc(sel_rc),
        .alu_op(alu_op), .mem_read(mem_read), .mem_write(mem_write),
        .mem_done(mem_done), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .bus_o(bus_o),
        .con_o(con_o), .n_zero(n_zero), .ir_op(ir_op)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        {clr_pc, clr_gpr, pc_out, md_out, c_out, r_out, ba_out, c1_out, c2_out} = '0;
        {pc_in, ir_in, ma_in, md_in, a_in, c_in, r_in, con_in, n_ld, n_dec} = '0;
        {sel_ra, sel_rb, sel_rc, mem_read, mem_write, mem_done} = '0;
        alu_op = 4'd0;
        mem_rdata = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Put v into MD through a one-wait read.
    task automatic mem_load(input logic [31:0] v);
        mem_read = 1'b1; tick(); mem_read = 1'b0;
        mem_done = 1'b1; mem_rdata = v; tick();
        mem_done = 1'b0; mem_rdata = '0;
    endtask

    task automatic set_ir(input logic [31:0] v);
        mem_load(v);
        md_out = 1'b1; ir_in = 1'b1; tick(); idle();
    endtask

    task automatic write_gpr(input int idx, input logic [31:0] v);
        set_ir({5'd0, 5'(idx), 22'd0});
        mem_load(v);
        md_out = 1'b1; sel_ra = 1'b1; r_in = 1'b1; tick(); idle();
    endtask

    task automatic read_ra(input int idx, input bit base, output logic [31:0] v);
        set_ir({5'd0, 5'(idx), 22'd0});
        sel_ra = 1'b1;
        if (base) ba_out = 1'b1; else r_out = 1'b1;
        #2 v = bus_o;
        idle();
    endtask

    task automatic run_alu(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                           output logic [31:0] y);
        mem_load(a);
        md_out = 1'b1; a_in = 1'b1; tick(); idle();
        mem_load(b);
        md_out = 1'b1; alu_op = op; c_in = 1'b1; tick(); idle();
        c_out = 1'b1; #2 y = bus_o; idle();
    endtask

    function automatic logic [31:0] alu_ref(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
        case (op)
            4'd0:  return a + b;
            4'd1:  return a - b;
            4'd2:  return a & b;
            4'd3:  return a | b;
            4'd4:  return b / 2;
            4'd5:  return (b / 2) | (b & 32'h8000_0000);
            4'd6:  return b * 2;
            4'd7:  return (b * 2) + (b >> 31);
            4'd8:  return 32'hFFFF_FFFF ^ b;
            4'd9:  return (32'hFFFF_FFFF ^ b) + 1;
            4'd10: return b;
            4'd11: return b + 4;
            default: return 32'd0;
        endcase
    endfunction

    function automatic bit cond_ref(input int code, input logic [31:0] v);
        case (code)
            1: return 1'b1;
            2: return v == 0;
            3: return v != 0;
            4: return v < 32'h8000_0000;
            5: return v >= 32'h8000_0000;
            default: return 1'b0;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    logic [31:0] vals [8];

    initial begin
        logic [31:0] got;
        vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'hFFFF_FFFF;
        vals[3] = 32'h8000_0000; vals[4] = 32'h7FFF_FFFF; vals[5] = 32'h1234_5678;
        vals[6] = 32'hA5A5_0F0F; vals[7] = 32'h0000_0004;
        idle();
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1 reset state; R2 idle bus
        #2;
        check("R1 bus", bus_o, 32'd0);
        check("R2 idle bus", bus_o, 32'd0);
        check("R1 con", {31'd0, con_o}, 32'd0);
        check("R1 n_zero", {31'd0, n_zero}, 32'd1);
        check("R1 mem_rd", {31'd0, mem_rd}, 32'd0);
        check("R1 mem_wr", {31'd0, mem_wr}, 32'd0);
        check("R1 mem_addr", mem_addr, 32'd0);
        pc_out = 1'b1; #2 check("R1 pc", bus_o, 32'd0); idle();

        // R9 read handshake with an extra wait cycle
        mem_read = 1'b1; tick(); mem_read = 1'b0;
        check("R9 rd raised", {31'd0, mem_rd}, 32'd1);
        tick();
        check("R9 rd held", {31'd0, mem_rd}, 32'd1);
        mem_done = 1'b1; mem_rdata = 32'hDEAD_BEEF; tick(); idle();
        check("R9 rd dropped", {31'd0, mem_rd}, 32'd0);
        md_out = 1'b1; #2 check("R9 md data", bus_o, 32'hDEAD_BEEF); idle();

        // R10 write handshake; R11 MA from bus
        mem_load(32'h0000_0100);
        md_out = 1'b1; ma_in = 1'b1; tick(); idle();
        check("R11 ma", mem_addr, 32'h0000_0100);
        mem_load(32'hCAFE_0001);
        mem_write = 1'b1; tick(); mem_write = 1'b0;
        check("R10 wr raised", {31'd0, mem_wr}, 32'd1);
        tick(); tick();
        check("R10 wr held", {31'd0, mem_wr}, 32'd1);
        check("R10 wdata", mem_wdata, 32'hCAFE_0001);
        check("R10 addr", mem_addr, 32'h0000_0100);
        mem_done = 1'b1; tick(); idle();
        check("R10 wr dropped", {31'd0, mem_wr}, 32'd0);

        // R13 opcode field; R3 field decoding
        set_ir({5'd29, 5'd3, 5'd7, 5'd11, 12'd0});
        check("R13 op", {27'd0, ir_op}, 32'd29);
        write_gpr(3, 32'h3333_0003);
        write_gpr(7, 32'h7777_0007);
        write_gpr(11, 32'hBBBB_000B);
        set_ir({5'd29, 5'd3, 5'd7, 5'd11, 12'd0});
        sel_ra = 1'b1; r_out = 1'b1; #2 check("R3 ra", bus_o, 32'h3333_0003); idle();
        sel_rb = 1'b1; r_out = 1'b1; #2 check("R3 rb", bus_o, 32'h7777_0007); idle();
        sel_rc = 1'b1; r_out = 1'b1; #2 check("R3 rc", bus_o, 32'hBBBB_000B); idle();

        // R4 base-address gate
        write_gpr(0, 32'h0000_1234);
        read_ra(0, 1'b0, got); check("R4 r0 normal", got, 32'h0000_1234);
        read_ra(0, 1'b1, got); check("R4 r0 base", got, 32'd0);
        read_ra(7, 1'b1, got); check("R4 r7 base", got, 32'h7777_0007);

        // R5 constants
        set_ir(32'h0001_2345);
        c2_out = 1'b1; #2 check("R5 c2 neg", bus_o, 32'hFFFF_2345); idle();
        c1_out = 1'b1; #2 check("R5 c1 pos", bus_o, 32'h0001_2345); idle();
        set_ir(32'h0020_8001);
        c2_out = 1'b1; #2 check("R5 c2 pos", bus_o, 32'h0000_8001); idle();
        c1_out = 1'b1; #2 check("R5 c1 neg", bus_o, 32'hFFE0_8001); idle();

        // R6 ALU sweep
        for (int op = 0; op < 16; op++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j += 3) begin
                    run_alu(4'(op), vals[i], vals[j], got);
                    check($sformatf("R6 op%0d", op), got, alu_ref(4'(op), vals[i], vals[j]));
                end

        // R7 condition codes
        for (int code = 0; code < 8; code++)
            for (int i = 0; i < 8; i++) begin
                set_ir({29'd0, 3'(code)});
                mem_load(vals[i]);
                md_out = 1'b1; con_in = 1'b1; tick(); idle();
                check($sformatf("R7 code%0d", code), {31'd0, con_o}, {31'd0, cond_ref(code, vals[i])});
            end

        // R8 counter
        mem_load(32'hFFFF_FFED);
        md_out = 1'b1; n_ld = 1'b1; tick(); idle();
        for (int k = 13; k > 0; k--) begin
            check("R8 nonzero", {31'd0, n_zero}, 32'd0);
            n_dec = 1'b1; tick(); idle();
        end
        check("R8 reached zero", {31'd0, n_zero}, 32'd1);
        n_dec = 1'b1; tick(); idle();
        check("R8 floor", {31'd0, n_zero}, 32'd1);
        mem_load(32'h0000_0020);
        md_out = 1'b1; n_ld = 1'b1; tick(); idle();
        check("R8 low bits only", {31'd0, n_zero}, 32'd1);
        mem_load(32'h0000_0001);
        md_out = 1'b1; n_ld = 1'b1; n_dec = 1'b1; tick(); idle();
        check("R8 load wins", {31'd0, n_zero}, 32'd0);

        // R11 fetch-style increment
        for (int k = 1; k <= 3; k++) begin
            pc_out = 1'b1; ma_in = 1'b1; alu_op = 4'd11; c_in = 1'b1; tick(); idle();
            c_out = 1'b1; pc_in = 1'b1; tick(); idle();
            check("R11 ma tracks pc", mem_addr, 32'(4 * (k - 1)));
            pc_out = 1'b1; #2 check("R11 pc+4", bus_o, 32'(4 * k)); idle();
        end

        // R12 clears
        mem_load(32'h0000_0040);
        md_out = 1'b1; pc_in = 1'b1; clr_pc = 1'b1; tick(); idle();
        pc_out = 1'b1; #2 check("R12 pc clear", bus_o, 32'd0); idle();
        write_gpr(31, 32'h1F1F_1F1F);
        clr_gpr = 1'b1; tick(); idle();
        for (int r = 0; r < 32; r++) begin
            read_ra(r, 1'b0, got);
            check($sformatf("R12 gpr%0d", r), got, 32'd0);
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule